// File: doc/BRIEF.md
# Steering Guard-Time Validator

This block turns a raw early-steering flag from a tone detector into a clean delayed-steering flag. The early flag may chatter at the start and end of a tone burst or drop out for a moment in mid-burst. The validator raises its output only after the early flag has been present without a break for a tone-present guard interval. It drops the output only after the flag has been absent without a break for a tone-absent guard interval. Short bursts are rejected, and short dropouts inside a valid burst are bridged.

One counter times both intervals. While the output is low, the counter measures how long the flag has been present. While the output is high, it measures how long the flag has been absent. Any break in the condition being timed clears the counter. The early flag is brought into the clock domain through a synchronizer of configurable depth. Both guard intervals are independent parameters in reference-clock cycles. By default each is derived from a reference rate and a time of 40 ms. A power-down input clears the output, the counter and the synchronizer.

Top module: `steer_guard_validator`

## Requirements
- R1: While reset is high, `dly_o` is 0 from the first clock edge. After reset is released, the first rise again needs the full latency given in R2.
- R2: With `dly_o` low, `dly_o` becomes 1 right after the (SYNC_STAGES + PRESENT_CYC)-th consecutive clock edge that samples `est_i` high.
- R3: A high burst on `est_i` that is sampled on fewer than PRESENT_CYC consecutive edges leaves `dly_o` at 0. A later burst is timed from its own start.
- R4: With `dly_o` high, `dly_o` becomes 0 right after the (SYNC_STAGES + ABSENT_CYC)-th consecutive clock edge that samples `est_i` low.
- R5: A low dropout on `est_i` that is sampled on fewer than ABSENT_CYC consecutive edges leaves `dly_o` at 1. A later dropout is timed from its own start.
- R6: `dly_o` holds 1 for as long as `est_i` stays high, and holds 0 for as long as `est_i` stays low.
- R7: A clock edge that samples `pwdn_i` high drives `dly_o` to 0, whatever `est_i` does. `dly_o` stays 0 while `pwdn_i` is high, including when power-down arrives during an absent interval.
- R8: After `pwdn_i` falls with `est_i` high, the rise takes the full latency of R2, because the counter and the synchronizer restart from zero.
- R9: PRESENT_CYC and ABSENT_CYC act independently. Each sets only its own interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| est_i | input | 1 | Early-steering flag from the tone detector, asynchronous |
| pwdn_i | input | 1 | Power-down, active high; forces the output low |
| dly_o | output | 1 | Validated (delayed) steering flag, registered |

## Verification
An off-by-one in the counter's terminal value, or in how it is re-armed, moves the edge of `dly_o` by whole clock cycles. The checks therefore sample one cycle before and exactly at the expected rise and fall of `dly_o`. If the counter is not cleared on a break, an aborted burst or a bridged dropout shortens the next interval. This shows within SYNC_STAGES plus the longer guard interval of cycles. A wrong state after power-down or reset shows as an early rise on the first burst that follows.

// File: rtl/steer_guard_pkg.sv
`timescale 1ns/1ps
package steer_guard_pkg;

  // Output state of the validator; the encoding equals the output level.
  typedef enum logic {
    GUARD_LOW  = 1'b0,
    GUARD_HIGH = 1'b1
  } guard_state_e;

  // Converts a time in milliseconds into reference-clock cycles.
  function automatic int unsigned ms_to_cycles(input int unsigned ref_hz,
                                               input int unsigned ms);
    return (ref_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/steer_guard_sync.sv
`timescale 1ns/1ps
module steer_guard_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] sh;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic nxt;
      logic q;
      if (g == 0) begin : g_first
        assign nxt = d_i;
      end else begin : g_next
        assign nxt = sh[g-1];
      end
      always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) q <= 1'b0;
        else                q <= nxt;
      end
      assign sh[g] = q;
    end

    assign q_o = sh[STAGES-1];

    // R7 / R8: power-down empties the whole chain so the next burst starts fresh
    p_chain_flush_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (sh == '0));
  end

endmodule

// File: rtl/steer_guard_timer.sv
`timescale 1ns/1ps
module steer_guard_timer #(
  parameter int unsigned PRESENT_CYC = 8,
  parameter int unsigned ABSENT_CYC  = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic run_i,
  input  logic sel_absent_i,
  output logic done_o
);

  localparam int unsigned MAX_CYC = (PRESENT_CYC > ABSENT_CYC) ? PRESENT_CYC : ABSENT_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_P   = CNT_W'(PRESENT_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_A   = CNT_W'(ABSENT_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_MAX = CNT_W'(MAX_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last   = sel_absent_i ? LAST_A : LAST_P;
  assign done_o = run_i && !clr_i && (cnt == last);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || !run_i || done_o) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end

  // R2 / R4: the count never passes the longer guard interval
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= LAST_MAX);

  // R3 / R5: a break in the timed condition restarts the interval
  p_break_restart_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_i && !clr_i) |=> (cnt == '0));

endmodule

// File: rtl/steer_guard_validator.sv
`timescale 1ns/1ps
module steer_guard_validator
  import steer_guard_pkg::*;
#(
  parameter int unsigned REF_HZ      = 1_000_000,
  parameter int unsigned PRESENT_MS  = 40,
  parameter int unsigned ABSENT_MS   = 40,
  parameter int unsigned PRESENT_CYC = ms_to_cycles(REF_HZ, PRESENT_MS),
  parameter int unsigned ABSENT_CYC  = ms_to_cycles(REF_HZ, ABSENT_MS),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic est_i,
  input  logic pwdn_i,
  output logic dly_o
);

  guard_state_e state;
  logic         est_s;
  logic         run;
  logic         done;

  steer_guard_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (pwdn_i),
    .d_i   (est_i),
    .q_o   (est_s)
  );

  // Low: time how long the flag is present. High: time how long it is absent.
  assign run = (state == GUARD_LOW) ? est_s : !est_s;

  steer_guard_timer #(
    .PRESENT_CYC (PRESENT_CYC),
    .ABSENT_CYC  (ABSENT_CYC)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .clr_i        (pwdn_i),
    .run_i        (run),
    .sel_absent_i (state == GUARD_HIGH),
    .done_o       (done)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || pwdn_i)  state <= GUARD_LOW;
    else if (done)        state <= (state == GUARD_LOW) ? GUARD_HIGH : GUARD_LOW;
  end

  assign dly_o = (state == GUARD_HIGH);

  // R2: a rise only follows an edge that saw the synchronized flag high
  p_rise_on_present_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(dly_o) && !$past(rst_i)) |-> ($past(est_s) && !$past(pwdn_i)));

  // R4: a fall not caused by power-down follows an edge that saw the flag low
  p_fall_on_absent_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(dly_o) && !$past(rst_i) && !$past(pwdn_i)) |-> !$past(est_s));

  // R6: the output holds while the flag agrees with it
  p_hold_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (dly_o && est_s && !pwdn_i) |=> dly_o);

  p_hold_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!dly_o && !est_s) |=> !dly_o);

  // R7: power-down forces the output low on the next edge
  p_pwdn_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    pwdn_i |=> !dly_o);

endmodule

// File: tb/test_steer_guard_validator.sv
`timescale 1ns/1ps
module test_steer_guard_validator;

  localparam int unsigned P_CYC = 8;
  localparam int unsigned A_CYC = 12;
  localparam int unsigned S_STG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic est = 1'b0;
  logic pwdn = 1'b0;
  logic dly;
  logic dly_alt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  steer_guard_validator #(
    .PRESENT_CYC (P_CYC), .ABSENT_CYC (A_CYC), .SYNC_STAGES (S_STG)
  ) i_steer_guard_validator (
    .clk_i (clk), .rst_i (rst), .est_i (est), .pwdn_i (pwdn), .dly_o (dly)
  );

  // Second instance with other intervals, for R9
  steer_guard_validator #(
    .PRESENT_CYC (3), .ABSENT_CYC (2), .SYNC_STAGES (S_STG)
  ) i_steer_guard_validator_alt (
    .clk_i (clk), .rst_i (rst), .est_i (est), .pwdn_i (pwdn), .dly_o (dly_alt)
  );

  typedef struct packed {
    logic       est;
    logic       pwdn;
    logic [7:0] cyc;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  // Rise at edge S+P = 10, fall at edge S+A = 14
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 8'd20, 1'b0, 4'd6},  // R6 idle low
    '{1'b1, 1'b0, 8'd9,  1'b0, 4'd2},  // R2 one edge short
    '{1'b1, 1'b0, 8'd1,  1'b1, 4'd2},  // R2 rise exactly on time
    '{1'b1, 1'b0, 8'd30, 1'b1, 4'd6},  // R6 held high
    '{1'b0, 1'b0, 8'd13, 1'b1, 4'd4},  // R4 one edge short
    '{1'b0, 1'b0, 8'd1,  1'b0, 4'd4},  // R4 fall exactly on time
    '{1'b1, 1'b0, 8'd7,  1'b0, 4'd3},  // R3 burst of P-1
    '{1'b0, 1'b0, 8'd3,  1'b0, 4'd3},  // R3 burst aborted
    '{1'b1, 1'b0, 8'd10, 1'b1, 4'd3},  // R3 next burst timed from its start
    '{1'b0, 1'b0, 8'd11, 1'b1, 4'd5},  // R5 dropout of A-1
    '{1'b1, 1'b0, 8'd3,  1'b1, 4'd5},  // R5 dropout bridged
    '{1'b0, 1'b0, 8'd14, 1'b0, 4'd5},  // R5 next dropout timed from its start
    '{1'b1, 1'b0, 8'd10, 1'b1, 4'd2},  // R2 rise again
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd7},  // R7 power-down clears at once
    '{1'b1, 1'b1, 8'd20, 1'b0, 4'd7},  // R7 held low
    '{1'b1, 1'b0, 8'd9,  1'b0, 4'd8},  // R8 restart needs full latency
    '{1'b1, 1'b0, 8'd1,  1'b1, 4'd8},  // R8 rise on time
    '{1'b0, 1'b0, 8'd5,  1'b1, 4'd7},  // R7 inside absent interval
    '{1'b0, 1'b1, 8'd1,  1'b0, 4'd7},  // R7 power-down during absent interval
    '{1'b0, 1'b0, 8'd20, 1'b0, 4'd6}   // R6 idle low
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic seg(input logic e, input logic p, input int cyc);
    est  = e;
    pwdn = p;
    repeat (cyc) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
  end

  initial begin
    // R1: reset state
    est = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dly, 1'b0, "R1 reset holds output low");
    est = 1'b0;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      seg(TBL[i].est, TBL[i].pwdn, int'(TBL[i].cyc));
      chk(dly, TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R9: intervals set independently (alt: rise at edge 5, fall at edge 4)
    seg(1'b1, 1'b0, 4);
    chk(dly_alt, 1'b0, "R9 alt before rise");
    seg(1'b1, 1'b0, 1);
    chk(dly_alt, 1'b1, "R9 alt rise after 5 edges");
    chk(dly, 1'b0, "R9 main still low after 5 edges");
    seg(1'b0, 1'b0, 3);
    chk(dly_alt, 1'b1, "R9 alt before fall");
    seg(1'b0, 1'b0, 1);
    chk(dly_alt, 1'b0, "R9 alt fall after 4 edges");

    // R1: reset while high, then full latency afterwards
    seg(1'b1, 1'b0, 20);
    chk(dly, 1'b1, "R1 high before reset");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(dly, 1'b0, "R1 reset clears high output");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    seg(1'b1, 1'b0, 9);
    chk(dly, 1'b0, "R1 no early rise after reset");
    seg(1'b1, 1'b0, 1);
    chk(dly, 1'b1, "R1 rise after reset on time");

    report();
  end

endmodule